// File: doc/BRIEF.md
# Cascadable serial bitstream memory

This block is a read-only store for a configuration bitstream that a loading device pulls out one bit per clock. An internal bit counter starts at zero and advances on each rising clock edge while the chip enable is active. The stored bit it points to appears on a one-bit serial output, which changes shortly after that edge. The output has a separate drive-enable signal so that a pad can tri-state it. Bits leave least significant first within each stored word, and the upper counter bits select the word.

Several copies can share the clock and data lines in a chain. When a copy has shifted out its last bit, it stops driving and pulls its active-low chip-enable-out low, which enables the next copy. A single combined pin clears the counter and also gates the output drive. Whether that pin is active high or active low is fixed by a parameter. The contents come in through a parallel word write port before readout begins.

Top module: `serial_bitstream_rom`

## Requirements
- R1: While `rst_ni` is low, the counter is held at zero and `ceo_no` is high. With `ce_ni` low and the reset/enable pin inactive, `data_oe_o` is 1 and `data_o` shows bit 0 of word 0.
- R2: Each rising edge of `clk_i` with `ce_ni` low, the pin inactive and the terminal count not reached adds one to the bit counter k. `data_o` then shows bit (k mod WORD_W) of word (k / WORD_W), starting with the least significant bit.
- R3: While `ce_ni` is high, the clock is ignored and the counter keeps its value. `data_oe_o` is 0 and `data_o` is 0.
- R4: While the reset/enable pin is active, `data_oe_o` and `data_o` are 0 at once. Each rising edge during that time sets the counter to zero, whatever the state of `ce_ni`.
- R5: With RST_POL = POL_HIGH the reset/enable pin is active at 1. With POL_LOW it is active at 0. Both builds behave the same for the same logical pin state.
- R6: After TC_BITS counting edges the counter stops. From then until a reset, `data_oe_o` and `data_o` are 0, and further edges change nothing.
- R7: `ceo_no` is low only when the terminal count has been reached and `ce_ni` is low. In every other case it is high.
- R8: A rising edge with `wr_en_i` high stores `wr_data_i` in word `wr_addr_i`. Later readout of that word shows the new bits. The counter is unaffected.
- R9: When the reset/enable pin is active on the edge that would reach the terminal count, the reset wins: the counter returns to zero and `ceo_no` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Serial read clock, rising edge |
| rst_ni | input | 1 | Asynchronous active-low system reset |
| ce_ni | input | 1 | Active-low chip enable |
| rst_oe_i | input | 1 | Combined counter reset / output enable, polarity set by RST_POL |
| wr_en_i | input | 1 | Word write strobe |
| wr_addr_i | input | $clog2(DEPTH) | Word address for writes |
| wr_data_i | input | WORD_W | Word to store |
| data_o | output | 1 | Serial data bit, 0 when not driving |
| data_oe_o | output | 1 | Drive enable for the serial data pad |
| ceo_no | output | 1 | Active-low chip enable for the next device in the chain |

## Verification
Two events can land on the same clock edge: the last counting step that would raise terminal count, and a reset through the combined pin. The bench streams exactly TC_BITS-1 bits and then asserts the pin so that it is active at the edge that would finish the stream. It passes if `ceo_no` never drops, the drive enable is off during the reset, and bit 0 of word 0 is back on the output once the pin is released. A second build with the opposite pin polarity receives the inverted pin and must match the first build at every check.

// File: rtl/sbr_pkg.sv
package sbr_pkg;
  typedef enum logic {
    POL_LOW  = 1'b0,
    POL_HIGH = 1'b1
  } pol_e;
endpackage

// File: rtl/sbr_addr_ctr.sv
module sbr_addr_ctr #(
  parameter int TC_BITS = 64,
  parameter int CNT_W   = $clog2(TC_BITS + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             done_o
);
  localparam logic [CNT_W-1:0] TC_VAL = CNT_W'(TC_BITS);

  logic [CNT_W-1:0] cnt_q;

  assign done_o = (cnt_q == TC_VAL);
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (clr_i) begin
      cnt_q <= '0;
    end else if (en_i && !done_o) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/sbr_cell_array.sv
module sbr_cell_array #(
  parameter int WORD_W = 8,
  parameter int DEPTH  = 8,
  parameter int CNT_W  = 7,
  localparam int AW    = $clog2(DEPTH),
  localparam int BW    = $clog2(WORD_W)
) (
  input  logic              clk_i,
  input  logic              wr_en_i,
  input  logic [AW-1:0]     wr_addr_i,
  input  logic [WORD_W-1:0] wr_data_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic              bit_o
);
  logic [WORD_W-1:0] mem_q [DEPTH];
  logic [AW-1:0]     word_sel;
  logic [BW-1:0]     bit_sel;
  logic [WORD_W-1:0] word_rd;

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[wr_addr_i] <= wr_data_i;
  end

  // upper counter bits pick the word, lower bits the bit (LSB first)
  assign word_sel = AW'(cnt_i >> BW);
  assign bit_sel  = BW'(cnt_i);
  assign word_rd  = mem_q[word_sel];
  assign bit_o    = word_rd[bit_sel];
endmodule

// File: rtl/sbr_out_ctl.sv
module sbr_out_ctl #(
  parameter sbr_pkg::pol_e RST_POL = sbr_pkg::POL_LOW
) (
  input  logic rst_oe_i,
  input  logic ce_ni,
  input  logic done_i,
  input  logic bit_i,
  output logic rst_act_o,
  output logic data_o,
  output logic data_oe_o,
  output logic ceo_no
);
  generate
    if (RST_POL == sbr_pkg::POL_HIGH) begin : g_pol_high
      assign rst_act_o = rst_oe_i;
    end else begin : g_pol_low
      assign rst_act_o = ~rst_oe_i;
    end
  endgenerate

  assign data_oe_o = ~ce_ni & ~rst_act_o & ~done_i;
  assign data_o    = data_oe_o & bit_i;
  assign ceo_no    = ~(done_i & ~ce_ni);
endmodule

// File: rtl/serial_bitstream_rom.sv
module serial_bitstream_rom #(
  parameter int            WORD_W  = 8,
  parameter int            DEPTH   = 8,
  parameter int            TC_BITS = WORD_W * DEPTH,
  parameter sbr_pkg::pol_e RST_POL = sbr_pkg::POL_LOW,
  localparam int           AW      = $clog2(DEPTH),
  localparam int           CNT_W   = $clog2(TC_BITS + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_ni,
  input  logic              rst_oe_i,
  input  logic              wr_en_i,
  input  logic [AW-1:0]     wr_addr_i,
  input  logic [WORD_W-1:0] wr_data_i,
  output logic              data_o,
  output logic              data_oe_o,
  output logic              ceo_no
);
  logic [CNT_W-1:0] cnt_q;
  logic             done;
  logic             rst_act;
  logic             rd_bit;

  sbr_out_ctl #(.RST_POL(RST_POL)) u_out (
    .rst_oe_i (rst_oe_i),
    .ce_ni    (ce_ni),
    .done_i   (done),
    .bit_i    (rd_bit),
    .rst_act_o(rst_act),
    .data_o   (data_o),
    .data_oe_o(data_oe_o),
    .ceo_no   (ceo_no)
  );

  sbr_addr_ctr #(.TC_BITS(TC_BITS), .CNT_W(CNT_W)) u_ctr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (rst_act),
    .en_i  (~ce_ni),
    .cnt_o (cnt_q),
    .done_o(done)
  );

  sbr_cell_array #(.WORD_W(WORD_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_mem (
    .clk_i    (clk_i),
    .wr_en_i  (wr_en_i),
    .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i),
    .cnt_i    (cnt_q),
    .bit_o    (rd_bit)
  );
endmodule

// File: rtl/sbr_checker.sv
module sbr_checker #(
  parameter int            TC_BITS = 64,
  parameter sbr_pkg::pol_e RST_POL = sbr_pkg::POL_LOW,
  parameter int            CNT_W   = 7
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ce_ni,
  input logic             rst_oe_i,
  input logic             data_oe_o,
  input logic             ceo_no,
  input logic [CNT_W-1:0] cnt_i
);
  localparam logic [CNT_W-1:0] TC_VAL = CNT_W'(TC_BITS);
  logic pin_act;
  assign pin_act = (RST_POL == sbr_pkg::POL_HIGH) ? rst_oe_i : ~rst_oe_i;

  // R2
  a_r2_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ce_ni && !pin_act && cnt_i != TC_VAL) |=> cnt_i == $past(cnt_i) + 1'b1);
  // R3
  a_r3_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce_ni && !pin_act) |=> $stable(cnt_i));
  // R4
  a_r4_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pin_act |=> cnt_i == '0);
  a_r4_no_drive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pin_act |-> !data_oe_o);
  // R6
  a_r6_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_i == TC_VAL && !pin_act) |=> cnt_i == TC_VAL);
  a_r6_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ceo_no |-> !data_oe_o);
  // R7
  a_r7_ceo_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ce_ni |-> ceo_no);
endmodule

bind serial_bitstream_rom sbr_checker #(
  .TC_BITS(TC_BITS), .RST_POL(RST_POL), .CNT_W(CNT_W)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .ce_ni    (ce_ni),
  .rst_oe_i (rst_oe_i),
  .data_oe_o(data_oe_o),
  .ceo_no   (ceo_no),
  .cnt_i    (cnt_q)
);

// File: tb/serial_bitstream_rom_test.sv
module serial_bitstream_rom_test;
  localparam int CLK_PERIOD = 10;
  localparam int WORD_W  = 8;
  localparam int DEPTH   = 8;
  localparam int TC_BITS = 40;
  localparam int AW      = $clog2(DEPTH);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_n = 1'b0;
  logic roe = 1'b0;  // logical "reset/disable active"
  logic wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [WORD_W-1:0] wr_data = '0;
  logic d_hi, oe_hi, ceo_hi, d_lo, oe_lo, ceo_lo;
  logic [WORD_W-1:0] model [DEPTH];
  int n_tests = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_bitstream_rom #(.WORD_W(WORD_W), .DEPTH(DEPTH), .TC_BITS(TC_BITS),
    .RST_POL(sbr_pkg::POL_HIGH)) uut (
    .clk_i(clk), .rst_ni(rst_n), .ce_ni(ce_n), .rst_oe_i(roe),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .data_o(d_hi), .data_oe_o(oe_hi), .ceo_no(ceo_hi));

  serial_bitstream_rom #(.WORD_W(WORD_W), .DEPTH(DEPTH), .TC_BITS(TC_BITS),
    .RST_POL(sbr_pkg::POL_LOW)) uut_lo (
    .clk_i(clk), .rst_ni(rst_n), .ce_ni(ce_n), .rst_oe_i(~roe),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .data_o(d_lo), .data_oe_o(oe_lo), .ceo_no(ceo_lo));

  function automatic logic exp_bit(input int k);
    logic [WORD_W-1:0] w;
    w = model[k / WORD_W];
    return w[k % WORD_W];
  endfunction

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input logic got, input logic exp, input string tag);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0b expected %0b", tag, got, exp);
    end
  endtask

  task automatic chk_out(input logic e_d, input logic e_oe, input logic e_ceo, input string tag);
    chk(d_hi, e_d, {tag, " data"});
    chk(oe_hi, e_oe, {tag, " oe"});
    chk(ceo_hi, e_ceo, {tag, " ceo"});
    // R5: opposite-polarity build must agree
    chk(d_lo, e_d, {"R5 ", tag, " data lo"});
    chk(oe_lo, e_oe, {"R5 ", tag, " oe lo"});
    chk(ceo_lo, e_ceo, {"R5 ", tag, " ceo lo"});
  endtask

  task automatic write_word(input int a, input logic [WORD_W-1:0] v);
    wr_en = 1'b1; wr_addr = AW'(a); wr_data = v;
    model[a] = v;
    step();
    wr_en = 1'b0;
  endtask

  task automatic t_reset();
    for (int w = 0; w < DEPTH; w++) write_word(w, WORD_W'(w * 37 + 11));
    chk_out(exp_bit(0), 1'b1, 1'b1, "R1 reset state");
    rst_n = 1'b1;
    #1;
    chk_out(exp_bit(0), 1'b1, 1'b1, "R1 after release");
  endtask

  task automatic t_stream();
    for (int k = 1; k <= 13; k++) begin
      step();
      chk_out(exp_bit(k), 1'b1, 1'b1, "R2 stream bit");
    end
  endtask

  task automatic t_ce_hold();
    ce_n = 1'b1;
    #1;
    chk_out(1'b0, 1'b0, 1'b1, "R3 ce off");
    for (int i = 0; i < 5; i++) begin
      step();
      chk_out(1'b0, 1'b0, 1'b1, "R3 R7 ce off clocked");
    end
    ce_n = 1'b0;
    #1;
    chk_out(exp_bit(13), 1'b1, 1'b1, "R3 counter held");
  endtask

  task automatic t_oe_reset();
    roe = 1'b1; ce_n = 1'b1;
    #1;
    chk_out(1'b0, 1'b0, 1'b1, "R4 pin active");
    step();
    roe = 1'b0; ce_n = 1'b0;
    #1;
    chk_out(exp_bit(0), 1'b1, 1'b1, "R4 cleared with ce off");
  endtask

  task automatic t_write();
    write_word(1, 8'hA5);  // counter advances to 1 during this edge
    chk_out(exp_bit(1), 1'b1, 1'b1, "R8 counter unaffected");
    for (int k = 2; k <= 15; k++) begin
      step();
      chk_out(exp_bit(k), 1'b1, 1'b1, "R8 new word readout");
    end
  endtask

  task automatic t_terminal();
    for (int k = 16; k < TC_BITS; k++) begin
      step();
      chk_out(exp_bit(k), 1'b1, 1'b1, "R2 stream to end");
    end
    step();
    chk_out(1'b0, 1'b0, 1'b0, "R6 R7 terminal");
    for (int i = 0; i < 3; i++) begin
      step();
      chk_out(1'b0, 1'b0, 1'b0, "R6 stays done");
    end
    ce_n = 1'b1;
    #1;
    chk_out(1'b0, 1'b0, 1'b1, "R7 ceo needs own ce");
    ce_n = 1'b0;
    #1;
    chk_out(1'b0, 1'b0, 1'b0, "R7 ceo back");
    roe = 1'b1;
    step();
    roe = 1'b0;
    #1;
    chk_out(exp_bit(0), 1'b1, 1'b1, "R6 reset leaves done");
  endtask

  task automatic t_collide();
    for (int k = 1; k < TC_BITS; k++) step();
    chk_out(exp_bit(TC_BITS - 1), 1'b1, 1'b1, "R9 last bit");
    roe = 1'b1;
    step();
    chk_out(1'b0, 1'b0, 1'b1, "R9 reset wins");
    roe = 1'b0;
    #1;
    chk_out(exp_bit(0), 1'b1, 1'b1, "R9 restart");
    step();
    chk_out(exp_bit(1), 1'b1, 1'b1, "R9 counting again");
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_stream();
    t_ce_hold();
    t_oe_reset();
    t_write();
    t_terminal();
    t_collide();
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got hang expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule